// File: doc/BRIEF.md
# Vectored interrupt priority arbiter

This block collects interrupt requests from several peripherals and funnels them into one processor interrupt line. While at least one request is waiting, it raises the processor interrupt. The processor answers by raising its acknowledge. On the rising edge of that acknowledge, the arbiter picks exactly one requester and raises that peripheral's acknowledge. The chosen peripheral then drives its service vector onto the data bus. The vector storage and the processor's response are modelled only in the testbench. When the processor lowers its acknowledge, the peripheral acknowledge drops and the handshake is over.

The winner is chosen by one of two priority schemes, set through a one-bit configuration write from the system bus. In fixed mode the lowest input index always wins. In rotating mode, once a requester has been served it becomes the lowest priority, and the search starts at the next index and wraps around. The control flow is a three-state machine:

- ST_IDLE: no handshake is in progress.
- ST_PEND: the processor interrupt is raised.
- ST_SERVE: one peripheral acknowledge is raised.

Its transitions are:

- T_RAISE (ST_IDLE to ST_PEND): some request is active.
- T_WITHDRAW (ST_PEND to ST_IDLE): all requests have gone.
- T_ACCEPT (ST_PEND to ST_SERVE): the acknowledge rises while a request is active.
- T_RELEASE (ST_SERVE to ST_IDLE): the acknowledge falls.

Top module: `irq_vec_arb`

## Requirements
- R1: During and right after reset, `cpu_irq_o` is 0, `per_ack_o` is all zeros, the mode is fixed and the rotation start index is 0.
- R2: From ST_IDLE, a nonzero `irq_req_i` sampled at a clock edge makes `cpu_irq_o` 1 after that edge. It stays 1 while requests remain and no acknowledge rise is seen.
- R3: If every request goes low while the interrupt is raised and before any acknowledge rise, `cpu_irq_o` returns to 0 after the next edge. A later acknowledge then produces no peripheral acknowledge.
- R4: An edge where `cpu_ack_i` is 1, having been 0 at the previous edge, while the interrupt is raised and a request is active, has two effects after that edge. `cpu_irq_o` goes to 0, and `per_ack_o` carries exactly one bit, which is the bit of the chosen requester.
- R5: While `cpu_ack_i` stays 1, `per_ack_o` holds its value whatever `irq_req_i` does.
- R6: After the first edge that samples `cpu_ack_i` at 0 during a grant, `per_ack_o` is all zeros.
- R7: In fixed mode, the active request with the smallest index wins, so bit 0 has the highest rank.
- R8: In rotating mode, serving index k moves the search start to k+1, wrapping from the last index to 0. The first active request at or after the start wins. The start index changes only on grants made in rotating mode.
- R9: An edge with `cfg_wr_i` = 1 loads `cfg_mode_i`, where 0 selects fixed and 1 selects rotating. When `cfg_wr_i` is 0, `cfg_mode_i` has no effect.
- R10: An acknowledge that is already high when the interrupt is raised grants nothing. Only a fresh rising edge of `cpu_ack_i` in ST_PEND grants.
- R11: `per_ack_o` never has more than one bit set, and it is never nonzero in the same cycle as `cpu_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe from the system bus |
| cfg_mode_i | input | 1 | Priority mode to load: 0 fixed, 1 rotating |
| irq_req_i | input | NUM_REQ | Per-peripheral interrupt requests |
| cpu_ack_i | input | 1 | Interrupt acknowledge from the processor |
| cpu_irq_o | output | 1 | Interrupt to the processor |
| per_ack_o | output | NUM_REQ | One-hot acknowledge to the granted peripheral |

## Verification
The properties assume that `cpu_ack_i` and `irq_req_i` are synchronous to `clk` and change only between edges. They also assume that the processor raises its acknowledge only as a two-phase reply, holding it until service is complete. The grant-legality property further relies on a peripheral's request being present at the edge where the acknowledge rise is sampled. The stimulus drives every input on the falling clock edge. It raises the acknowledge only after seeing the interrupt, apart from the one deliberate early-acknowledge case. It also alters requests during a grant only while the acknowledge is held high, so that the frozen-grant rule is exercised inside these assumptions.

// File: rtl/irq_vec_arb_pkg.sv
package irq_vec_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SERVE = 2'd2
    } arb_state_e;

    typedef enum logic {
        MODE_FIXED  = 1'b0,
        MODE_ROTATE = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/irq_vec_arb_cfg.sv
module irq_vec_arb_cfg
    import irq_vec_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_wr_i,
    input  logic      cfg_mode_i,
    output arb_mode_e mode_o
);

    arb_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FIXED;
        end else if (cfg_wr_i) begin
            mode_q <= arb_mode_e'(cfg_mode_i);
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/irq_vec_arb_pick.sv
module irq_vec_arb_pick
    import irq_vec_arb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  arb_mode_e          mode_i,
    input  logic [IDX_W-1:0]   start_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    localparam logic [IDX_W:0] NUM_EXT = (IDX_W+1)'(NUM_REQ);

    logic [IDX_W-1:0]     base;
    logic [2*NUM_REQ-1:0] doubled;
    logic [NUM_REQ-1:0]   rotated;
    logic [IDX_W-1:0]     offset;
    logic [IDX_W:0]       sum;

    // Fixed mode always searches from index 0.
    assign base    = (mode_i == MODE_ROTATE) ? start_i : '0;
    assign doubled = {req_i, req_i} >> base;
    assign rotated = doubled[NUM_REQ-1:0];
    assign any_o   = |req_i;

    always_comb begin
        offset = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (rotated[i]) begin
                offset = IDX_W'(i);
            end
        end
        sum = {1'b0, offset} + {1'b0, base};
        if (sum >= NUM_EXT) begin
            sum = sum - NUM_EXT;
        end
        idx_o = sum[IDX_W-1:0];
    end

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_onehot
            assign grant_o[g] = any_o && (idx_o == IDX_W'(g));
        end
    endgenerate

endmodule

// File: rtl/irq_vec_arb_ptr.sv
module irq_vec_arb_ptr #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [IDX_W-1:0] served_i,
    output logic [IDX_W-1:0] start_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REQ - 1);

    logic [IDX_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (upd_i) begin
            start_q <= (served_i == LAST) ? '0 : served_i + IDX_W'(1);
        end
    end

    assign start_o = start_q;

endmodule

// File: rtl/irq_vec_arb_fsm.sv
module irq_vec_arb_fsm
    import irq_vec_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_req_i,
    input  logic       ack_rise_i,
    input  logic       ack_fall_i,
    output arb_state_e state_o,
    output logic       load_grant_o,
    output logic       release_o,
    output logic       irq_o,
    output logic       serve_o
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        load_grant_o = 1'b0;
        release_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // T_RAISE
                if (any_req_i) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!any_req_i) begin
                    // T_WITHDRAW
                    state_d = ST_IDLE;
                end else if (ack_rise_i) begin
                    // T_ACCEPT
                    state_d      = ST_SERVE;
                    load_grant_o = 1'b1;
                end
            end
            ST_SERVE: begin
                // T_RELEASE
                if (ack_fall_i) begin
                    state_d   = ST_IDLE;
                    release_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        irq_o   = (state_q == ST_PEND);
        serve_o = (state_q == ST_SERVE);
    end

    assign state_o = state_q;

endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
    import irq_vec_arb_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_i,
    input  logic               cfg_mode_i,
    input  logic [NUM_REQ-1:0] irq_req_i,
    input  logic               cpu_ack_i,
    output logic               cpu_irq_o,
    output logic [NUM_REQ-1:0] per_ack_o
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    arb_mode_e          mode;
    arb_state_e         state;
    logic               ack_q;
    logic               ack_rise;
    logic               ack_fall;
    logic [IDX_W-1:0]   start_idx;
    logic [NUM_REQ-1:0] pick_grant;
    logic [IDX_W-1:0]   pick_idx;
    logic               any_req;
    logic               load_grant;
    logic               release_grant;
    logic               irq_state;
    logic               serve_state;
    logic [NUM_REQ-1:0] grant_q;
    logic [IDX_W-1:0]   grant_idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= cpu_ack_i;
        end
    end

    assign ack_rise = cpu_ack_i && !ack_q;
    assign ack_fall = !cpu_ack_i && ack_q;

    irq_vec_arb_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_mode_i (cfg_mode_i),
        .mode_o     (mode)
    );

    irq_vec_arb_ptr #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (release_grant && (mode == MODE_ROTATE)),
        .served_i (grant_idx_q),
        .start_o  (start_idx)
    );

    irq_vec_arb_pick #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req_i   (irq_req_i),
        .mode_i  (mode),
        .start_i (start_idx),
        .grant_o (pick_grant),
        .idx_o   (pick_idx),
        .any_o   (any_req)
    );

    irq_vec_arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_req_i    (any_req),
        .ack_rise_i   (ack_rise),
        .ack_fall_i   (ack_fall),
        .state_o      (state),
        .load_grant_o (load_grant),
        .release_o    (release_grant),
        .irq_o        (irq_state),
        .serve_o      (serve_state)
    );

    // The grant is captured once, at the acknowledge rise, and held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q     <= '0;
            grant_idx_q <= '0;
        end else if (load_grant) begin
            grant_q     <= pick_grant;
            grant_idx_q <= pick_idx;
        end
    end

    assign cpu_irq_o = irq_state && (state == ST_PEND);
    assign per_ack_o = serve_state ? grant_q : '0;

endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] irq_req_i,
    input logic               cpu_ack_i,
    input logic               cpu_irq_o,
    input logic [NUM_REQ-1:0] per_ack_o
);

    // R11
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_ack_o));

    // R11
    irq_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_irq_o && (per_ack_o != '0)));

    // R5
    grant_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_ack_o != '0) && cpu_ack_i) |=> (per_ack_o == $past(per_ack_o)));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_ack_o != '0) && !cpu_ack_i) |=> (per_ack_o == '0));

    // R3
    irq_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_i == '0) |=> !cpu_irq_o);

    // R4
    grant_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack_o != '0) |-> ($past(cpu_ack_i) && $past(cpu_irq_o)));

    // R4
    grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack_o != '0) |-> (($past(irq_req_i) & per_ack_o) != '0));

endmodule

bind irq_vec_arb irq_vec_arb_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_i (irq_req_i),
    .cpu_ack_i (cpu_ack_i),
    .cpu_irq_o (cpu_irq_o),
    .per_ack_o (per_ack_o)
);

// File: tb/irq_vec_arb_test.sv
`timescale 1ns/1ps
module irq_vec_arb_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_i = 1'b0;
    logic         cfg_mode_i = 1'b0;
    logic [N-1:0] irq_req_i = '0;
    logic         cpu_ack_i = 1'b0;
    logic         cpu_irq_o;
    logic [N-1:0] per_ack_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    logic [N-1:0] prev_ack = '0;

    bit model_rot = 1'b0;
    int model_start = 0;

    always #2.5 clk = ~clk;

    irq_vec_arb #(.NUM_REQ(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_mode_i (cfg_mode_i),
        .irq_req_i  (irq_req_i),
        .cpu_ack_i  (cpu_ack_i),
        .cpu_irq_o  (cpu_irq_o),
        .per_ack_o  (per_ack_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_pick(input logic [N-1:0] req);
        int base = model_rot ? model_start : 0;
        for (int k = 0; k < N; k++) begin
            if (req[(base + k) % N]) return N'(1) << ((base + k) % N);
        end
        return '0;
    endfunction

    function automatic int onehot_idx(input logic [N-1:0] v);
        for (int k = 0; k < N; k++) if (v[k]) return k;
        return 0;
    endfunction

    // Scoreboard monitor: every new grant must match the next queued expectation.
    always @(negedge clk) begin
        if (rst_n && per_ack_o != '0 && prev_ack == '0) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: actual %0h expected 0 (unexpected grant)", per_ack_o);
            end else begin
                automatic logic [N-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (per_ack_o !== e) begin
                    fails++;
                    $display("FAIL %s: actual %0h expected %0h", t, per_ack_o, e);
                end
            end
        end
        prev_ack = per_ack_o;
    end

    task automatic handshake(input logic [N-1:0] req, input string tag);
        logic [N-1:0] e;
        @(negedge clk);
        irq_req_i = req;
        @(negedge clk);
        check(cpu_irq_o, 1, "R2");
        cpu_ack_i = 1'b1;
        e = model_pick(req);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        check(cpu_irq_o, 0, "R4");
        irq_req_i = ~req;
        @(negedge clk);
        @(negedge clk);
        check(per_ack_o, e, "R5");
        cpu_ack_i = 1'b0;
        irq_req_i = '0;
        if (model_rot) model_start = (onehot_idx(e) + 1) % N;
        @(negedge clk);
        check(per_ack_o, 0, "R6");
        check(cpu_irq_o, 0, "R6");
    endtask

    task automatic write_mode(input bit rot);
        @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_mode_i = rot;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        model_rot = rot;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_irq_o, 0, "R1");
        check(per_ack_o, 0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_irq_o, 0, "R1");

        // Fixed mode ranking
        handshake(4'b1010, "R7");
        handshake(4'b1100, "R7");
        handshake(4'b1111, "R7");

        // Requests withdrawn before acknowledge
        @(negedge clk);
        irq_req_i = 4'b0100;
        @(negedge clk);
        check(cpu_irq_o, 1, "R2");
        irq_req_i = '0;
        @(negedge clk);
        check(cpu_irq_o, 0, "R3");
        cpu_ack_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(per_ack_o, 0, "R3");
        cpu_ack_i = 1'b0;
        @(negedge clk);

        // Acknowledge already high before the interrupt
        cpu_ack_i = 1'b1;
        @(negedge clk);
        irq_req_i = 4'b0010;
        @(negedge clk);
        check(cpu_irq_o, 1, "R10");
        @(negedge clk);
        @(negedge clk);
        check(per_ack_o, 0, "R10");
        check(cpu_irq_o, 1, "R10");
        cpu_ack_i = 1'b0;
        @(negedge clk);
        cpu_ack_i = 1'b1;
        exp_q.push_back(4'b0010);
        tag_q.push_back("R10");
        @(negedge clk);
        check(per_ack_o, 4'b0010, "R10");
        cpu_ack_i = 1'b0;
        irq_req_i = '0;
        @(negedge clk);
        check(per_ack_o, 0, "R6");

        // Mode input without write strobe has no effect
        @(negedge clk);
        cfg_mode_i = 1'b1;
        @(negedge clk);
        cfg_mode_i = 1'b0;
        handshake(4'b0110, "R9");
        handshake(4'b0110, "R9");

        // Rotating mode
        write_mode(1'b1);
        handshake(4'b1111, "R8");
        handshake(4'b1111, "R8");
        handshake(4'b1111, "R8");
        handshake(4'b1111, "R8");
        handshake(4'b1001, "R8");
        handshake(4'b1001, "R8");
        handshake(4'b0110, "R8");

        // Back to fixed
        write_mode(1'b0);
        handshake(4'b1001, "R9");
        handshake(4'b1001, "R9");

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R4");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule